// File: doc/BRIEF.md
# Parallel Configuration Table Expander with Round-Robin Chain Distributor

This block sits behind a variable-length code decoder that can emit up to `NUM_SLOTS` short symbols per cycle. Each symbol is a `SYM_W`-bit index into a small table holding frequently used logic-block configurations of `CFG_W` bits. Every symbol slot has its own read port into that table, so all slots expand in the same cycle. A slot can instead be marked raw, in which case its full configuration arrives on the input and the table is skipped.

The expanded configurations are loaded into `NUM_SLOTS` parallel shift chains. A rotating pointer picks the chain for slot 0 of each group, and the following slots go to the following chains, so consecutive configurations land on consecutive chains. The pointer then moves on by the number of configurations in the group. Each chain shifts its configuration out serially, most significant bit first. The decoder is held off with `in_ready` until every chain has finished.

The table is filled through a write port of address and data while no distribution is in progress.

Top module: `cte_expander`

## Requirements
- R1: After reset `in_ready` is 1, every `chain_sen` bit is 0, and the rotation pointer is 0, so the first configuration accepted after reset goes to chain 0.
- R2: A valid slot with `in_raw` = 0 delivers the table entry addressed by its symbol (slot i uses `in_sym[i*SYM_W +: SYM_W]`).
- R3: A valid slot with `in_raw` = 1 delivers `in_raw_cfg[i*CFG_W +: CFG_W]` unchanged and does not alter the table; a later lookup of the same symbol still returns the stored entry.
- R4: Within an accepted group, slot i goes to chain (pointer + i) mod `NUM_SLOTS`; the pointer then advances by the number of valid slots, modulo `NUM_SLOTS`.
- R5: Valid slots are packed from slot 0 upward (bit i of `in_valid` set implies every lower bit set); chains not addressed by a valid slot stay idle.
- R6: A group is accepted at a rising edge where `in_ready` and any bit of `in_valid` are 1. The addressed chains raise `chain_sen` after the second following edge and hold it for exactly `CFG_W` cycles, presenting the configuration on `chain_sdo` most significant bit first, one bit per cycle.
- R7: `in_ready` is 0 from the cycle after an acceptance until every chain has shifted out its last bit; `in_valid` presented while `in_ready` is 0 is ignored.
- R8: Table writes (`tbl_we` = 1 stores `tbl_wdata` at `tbl_waddr`) are only issued while `in_ready` is 1 and `in_valid` is 0; a write takes effect for every group accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_SLOTS | Per-slot valid, packed from slot 0 |
| in_sym | input | NUM_SLOTS*SYM_W | Per-slot table index |
| in_raw | input | NUM_SLOTS | Per-slot flag: configuration given directly |
| in_raw_cfg | input | NUM_SLOTS*CFG_W | Per-slot direct configuration |
| in_ready | output | 1 | Block can accept a group this cycle |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | SYM_W | Table write address |
| tbl_wdata | input | CFG_W | Table write data |
| chain_sen | output | NUM_SLOTS | Per-chain shift strobe, high while a bit is presented |
| chain_sdo | output | NUM_SLOTS | Per-chain serial configuration bit |

## Verification
An accepted group passes one register stage for the table read and a second for the chain load, so the chain strobes are first visible in the cycle after the second rising edge following acceptance, and the serial bits follow for `CFG_W` cycles. The driver checks at the falling edge after the first edge that no strobe is up yet, and at the falling edge after the second that exactly the predicted chains are strobing while `in_ready` is low. A per-chain scoreboard collects the serial bits at falling edges and compares each completed configuration with the queue filled by the driver from its own pointer and table model.

// File: rtl/cte_pkg.sv
package cte_pkg;

  // Index width for a count of items, at least one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cte_table.sv
module cte_table #(
  parameter int SYM_W = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SYM_W-1:0] waddr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             re,
  input  logic [SYM_W-1:0] raddr,
  output logic [CFG_W-1:0] rdata
);
  localparam int DEPTH = 1 << SYM_W;

  logic [CFG_W-1:0] mem [DEPTH];

  // One write port, one registered read port: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cte_steer.sv
module cte_steer
  import cte_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      advance,
  input  logic [NUM_SLOTS-1:0]                      valid,
  output logic [NUM_SLOTS*idx_w(NUM_SLOTS)-1:0]     dest
);
  localparam int PTR_W = idx_w(NUM_SLOTS);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = PTR_W'((int'(ptr_q) + $countones(valid)) % NUM_SLOTS);
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dest
    assign dest[i*PTR_W +: PTR_W] = PTR_W'((int'(ptr_q) + i) % NUM_SLOTS);
  end

  a_r4_ptr_range: assert property (@(posedge clk) disable iff (rst)
    int'(ptr_q) < NUM_SLOTS);
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr_q));
endmodule

// File: rtl/cte_chain.sv
module cte_chain #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] load_data,
  output logic             sen,
  output logic             sdo,
  output logic             busy
);
  localparam int CNT_W = $clog2(CFG_W + 1);

  logic [CFG_W-1:0] sreg;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
      sreg <= '0;
    end else if (load) begin
      busy <= 1'b1;
      left <= CNT_W'(CFG_W);
      sreg <= load_data;
    end else if (busy) begin
      sreg <= sreg << 1;
      left <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign sen = busy;
  assign sdo = sreg[CFG_W-1];

  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  a_r6_start: assert property (@(posedge clk) disable iff (rst)
    $rose(sen) |-> $past(load));
  a_r6_first_bit: assert property (@(posedge clk) disable iff (rst)
    load |=> (sdo == $past(load_data[CFG_W-1])));
endmodule

// File: rtl/cte_expander.sv
module cte_expander
  import cte_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SYM_W     = 4,
  parameter int CFG_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOTS-1:0]       in_valid,
  input  logic [NUM_SLOTS*SYM_W-1:0] in_sym,
  input  logic [NUM_SLOTS-1:0]       in_raw,
  input  logic [NUM_SLOTS*CFG_W-1:0] in_raw_cfg,
  output logic                       in_ready,
  input  logic                       tbl_we,
  input  logic [SYM_W-1:0]           tbl_waddr,
  input  logic [CFG_W-1:0]           tbl_wdata,
  output logic [NUM_SLOTS-1:0]       chain_sen,
  output logic [NUM_SLOTS-1:0]       chain_sdo
);
  localparam int PTR_W = idx_w(NUM_SLOTS);

  logic                         accept;
  logic [NUM_SLOTS*PTR_W-1:0]   dest_flat;
  logic [CFG_W-1:0]             tbl_rd     [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]         s1_v;
  logic [NUM_SLOTS-1:0]         s1_raw;
  logic [CFG_W-1:0]             s1_cfg     [NUM_SLOTS];
  logic [PTR_W-1:0]             s1_dest    [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]         ch_load;
  logic [CFG_W-1:0]             ch_data    [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]         ch_busy;

  assign in_ready = !(|s1_v) && !(|ch_busy);
  assign accept   = in_ready && (|in_valid);

  cte_steer #(.NUM_SLOTS(NUM_SLOTS)) i_steer (
    .clk     (clk),
    .rst     (rst),
    .advance (accept),
    .valid   (in_valid),
    .dest    (dest_flat)
  );

  // Stage 1: one table read port per slot, plus capture of the bypass data.
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    cte_table #(.SYM_W(SYM_W), .CFG_W(CFG_W)) i_table (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (tbl_waddr),
      .wdata (tbl_wdata),
      .re    (accept && in_valid[i]),
      .raddr (in_sym[i*SYM_W +: SYM_W]),
      .rdata (tbl_rd[i])
    );

    always_ff @(posedge clk) begin
      if (accept) begin
        s1_raw[i]  <= in_raw[i];
        s1_cfg[i]  <= in_raw_cfg[i*CFG_W +: CFG_W];
        s1_dest[i] <= dest_flat[i*PTR_W +: PTR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         s1_v <= '0;
    else if (accept) s1_v <= in_valid;
    else             s1_v <= '0;
  end

  // Stage 2: route each slot to its chain and load it.
  for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_chain
    always_comb begin
      ch_load[c] = 1'b0;
      ch_data[c] = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (s1_v[i] && s1_dest[i] == PTR_W'(c)) begin
          ch_load[c] = 1'b1;
          ch_data[c] = s1_raw[i] ? s1_cfg[i] : tbl_rd[i];
        end
      end
    end

    cte_chain #(.CFG_W(CFG_W)) i_chain (
      .clk       (clk),
      .rst       (rst),
      .load      (ch_load[c]),
      .load_data (ch_data[c]),
      .sen       (chain_sen[c]),
      .sdo       (chain_sdo[c]),
      .busy      (ch_busy[c])
    );
  end

  a_r5_packed_valid: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((in_valid & (in_valid + 1'b1)) == '0));
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);
  a_r8_write_idle: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> (in_ready && !(|in_valid)));
  a_r5_load_count: assert property (@(posedge clk) disable iff (rst)
    $countones(ch_load) == $countones(s1_v));
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && chain_sen == '0));
endmodule

// File: tb/test_cte_expander.sv
module test_cte_expander;
  localparam int N  = 4;
  localparam int SW = 4;
  localparam int M  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   in_valid = '0;
  logic [N*SW-1:0] in_sym = '0;
  logic [N-1:0]   in_raw = '0;
  logic [N*M-1:0] in_raw_cfg = '0;
  logic           in_ready;
  logic           tbl_we = 1'b0;
  logic [SW-1:0]  tbl_waddr = '0;
  logic [M-1:0]   tbl_wdata = '0;
  logic [N-1:0]   chain_sen;
  logic [N-1:0]   chain_sdo;

  int vectors = 0;
  int fails   = 0;
  int ptr     = 0;
  logic [M-1:0] tbl_model [16];
  logic [M-1:0] exp_q [N][$];
  logic [M-1:0] acc [N];
  int           nbits [N];
  logic [15:0]  lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  cte_expander #(.NUM_SLOTS(N), .SYM_W(SW), .CFG_W(M)) i_cte_expander (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .in_raw(in_raw), .in_raw_cfg(in_raw_cfg), .in_ready(in_ready),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .chain_sen(chain_sen), .chain_sdo(chain_sdo)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: assemble serial bits per chain, compare to queue (R2 R3 R4 R6).
  initial begin
    for (int c = 0; c < N; c++) nbits[c] = 0;
    forever begin
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
        if (!rst && chain_sen[c]) begin
          acc[c] = {acc[c][M-2:0], chain_sdo[c]};
          nbits[c]++;
          if (nbits[c] == M) begin
            nbits[c] = 0;
            if (exp_q[c].size() == 0) begin
              check(1'b0, "R5 unexpected config", 64'(acc[c]), 64'(c));
            end else begin
              logic [M-1:0] e;
              e = exp_q[c].pop_front();
              check(acc[c] == e, "R2/R3/R4 chain content", 64'(acc[c]), 64'(e));
            end
          end
        end
      end
    end
  end

  function automatic logic [15:0] next_rand(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic write_tbl(input logic [SW-1:0] a, input logic [M-1:0] d);
    wait_idle();
    tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_model[a] = d;
  endtask

  // Driver: push expected configurations, apply one group, check timing.
  task automatic send(input int n, input logic [N*SW-1:0] syms,
                      input logic [N-1:0] raws, input logic [N*M-1:0] rcfg);
    logic [N-1:0] mask;
    wait_idle();
    mask = '0;
    for (int i = 0; i < n; i++) begin
      int c;
      c = (ptr + i) % N;
      mask[c] = 1'b1;
      if (raws[i]) exp_q[c].push_back(rcfg[i*M +: M]);
      else         exp_q[c].push_back(tbl_model[syms[i*SW +: SW]]);
    end
    ptr = (ptr + n) % N;
    in_valid = N'((1 << n) - 1); in_sym = syms; in_raw = raws; in_raw_cfg = rcfg;
    @(negedge clk);
    in_valid = '0;
    check(chain_sen == '0, "R6 no strobe one cycle after accept", 64'(chain_sen), 64'(0));
    check(in_ready == 1'b0, "R7 ready low after accept", 64'(in_ready), 64'(0));
    @(negedge clk);
    check(chain_sen == mask, "R6/R4/R5 strobes after second edge", 64'(chain_sen), 64'(mask));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'(1));
    check(chain_sen == '0, "R1 chains idle after reset", 64'(chain_sen), 64'(0));

    for (int a = 0; a < 16; a++) write_tbl(SW'(a), M'(16'h1357 * (a + 3)) ^ M'(a << 12));

    // R1 R2 R4: full group from pointer 0.
    send(4, {4'd3, 4'd2, 4'd1, 4'd0}, 4'b0000, '0);
    // R4: three slots, pointer moves by 3.
    send(3, {4'd0, 4'd15, 4'd9, 4'd7}, 4'b0000, '0);
    // R3: single raw slot.
    send(1, {12'd0, 4'd9}, 4'b0001, {48'd0, 16'hBEEF});
    // R7: inputs during busy are ignored.
    @(negedge clk);
    check(in_ready == 1'b0, "R7 busy during shift", 64'(in_ready), 64'(0));
    in_valid = 4'hF; in_sym = '1; in_raw = '0;
    @(negedge clk);
    in_valid = '0;
    // R3: lookup of symbol 9 still gives the stored entry; mixed raw/table.
    send(4, {4'd9, 4'd9, 4'd4, 4'd9}, 4'b0100, {16'h0, 16'hF00D, 16'h0, 16'h0});
    // R8: rewrite then use.
    write_tbl(4'd5, 16'h5A5A);
    send(2, {8'd0, 4'd5, 4'd5}, 4'b0010, {32'd0, 16'hC3C3, 16'd0});
    // Pseudo-random groups.
    for (int g = 0; g < 24; g++) begin
      logic [N*SW-1:0] s;
      logic [N*M-1:0]  r;
      int n;
      lfsr = next_rand(lfsr); n = 1 + (lfsr % N);
      lfsr = next_rand(lfsr); s = {lfsr, lfsr} >> (g % 4);
      r = '0;
      for (int i = 0; i < N; i++) begin
        lfsr = next_rand(lfsr); r[i*M +: M] = M'(lfsr);
      end
      lfsr = next_rand(lfsr);
      send(n, s, N'(lfsr), r);
    end

    wait_idle();
    repeat (2) @(negedge clk);
    for (int c = 0; c < N; c++)
      check(exp_q[c].size() == 0, "R4 all configs delivered", 64'(exp_q[c].size()), 64'(0));
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule